// File: doc/BRIEF.md
# Successive-Division Radix Converter

This block turns an unsigned binary integer into its digits in a chosen radix: 2, 8, 10 or 16. A start strobe loads the operand and the radix selection. From then on the block divides the held value by the radix once per clock cycle. The remainder of each division leaves the block as the next digit, and the quotient is kept for the next step.

Digits leave least significant first, one per cycle. Each digit is marked by a valid pulse, and the final digit also carries a last flag. The stream ends as soon as a quotient of zero appears, so the number of digits follows the value and is not fixed. A running digit count is shown beside the stream. Each division is done by an internal restoring divider that finishes in one cycle.

Top module: `radix_serial_conv`

## Requirements
- R1: After reset, `busy_o`, `dig_valid_o` and `dig_last_o` are 0 and `dig_count_o` is 0.
- R2: A `start_i` that is sampled high while `busy_o` is low does three things. It captures `value_i` and `radix_sel_i`, sets `busy_o` from the next cycle, and clears `dig_count_o` to 0. The radix selection codes are 0 for radix 2, 1 for radix 8, 2 for radix 10 and 3 for radix 16.
- R3: The first digit appears with `dig_valid_o` high in the cycle after `busy_o` rises. Its value is the operand modulo the radix.
- R4: Each further digit is the remainder of dividing the previous quotient by the radix, one per cycle, with no gaps. For example, 13 in radix 2 gives the digits 1, 0, 1, 1.
- R5: `dig_last_o` is high only on the digit whose division leaves a quotient of 0. `busy_o` is low in the cycle that shows that digit.
- R6: An operand of 0 gives exactly one digit, of value 0, with `dig_last_o` high.
- R7: Every digit is less than the radix. In radix 16 the digit values 10 to 15 appear on `dig_o` as the 4-bit codes 4'hA to 4'hF.
- R8: A `start_i` that is high while `busy_o` is high is ignored. The stream already running continues unchanged.
- R9: While a digit is shown, `dig_count_o` gives its 1-based position. After the last digit the count holds until the next accepted start. An all-ones 16-bit operand in radix 2 reaches the maximum count of 16.
- R10: A start given in the cycle that shows the last digit is accepted, so conversions can follow each other with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load strobe for operand and radix |
| value_i | input | OP_W (16) | Unsigned operand |
| radix_sel_i | input | 2 | Radix code: 0=2, 1=8, 2=10, 3=16 |
| busy_o | output | 1 | A conversion is in progress |
| dig_valid_o | output | 1 | `dig_o` holds a digit this cycle |
| dig_last_o | output | 1 | Current digit is the most significant one |
| dig_o | output | 4 | Digit value, 0 to radix-1 |
| dig_count_o | output | 5 | 1-based position of the current digit |

## Verification
The bench uses several kinds of operand:
- 13 in radix 2, the stated example.
- Zero, which must give a single digit.
- All-ones in every radix, which gives the longest stream for each radix and reaches the maximum count in radix 2.
- Values such as 0xABCD and 0x0F00 in radix 16, which tell the codes A to F apart and check that interior zero digits do not end the stream early.
- 9, 10, 99 and 65535 in radix 10, which sit at the boundaries where one more digit is needed.

A start strobe carrying a different operand is given in the middle of a stream, and the stream must stay unchanged. Conversions are also started in the cycle that shows the last digit, which checks that no cycle is lost between conversions.

// File: rtl/radix_conv_pkg.sv
package radix_conv_pkg;

  localparam int unsigned DIG_W = 4;
  localparam int unsigned DEN_W = 5;

  typedef enum logic [1:0] {
    RSEL_BIN = 2'd0,
    RSEL_OCT = 2'd1,
    RSEL_DEC = 2'd2,
    RSEL_HEX = 2'd3
  } radix_sel_e;

  function automatic logic [DEN_W-1:0] radix_of(input logic [1:0] sel);
    logic [DEN_W-1:0] r;
    case (sel)
      RSEL_BIN: r = 5'd2;
      RSEL_OCT: r = 5'd8;
      RSEL_DEC: r = 5'd10;
      default:  r = 5'd16;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/radix_rst_sync.sv
module radix_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/radix_restore_div.sv
module radix_restore_div #(
  parameter int unsigned NUM_W = 16,
  parameter int unsigned DEN_W = 5
) (
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic [DEN_W-1:0] rem_o
);

  localparam int unsigned TRY_W = DEN_W + 1;

  logic [DEN_W-1:0] part [0:NUM_W];

  assign part[NUM_W] = '0;

  for (genvar i = NUM_W - 1; i >= 0; i--) begin : g_stage
    logic [TRY_W-1:0] shifted;
    logic [TRY_W-1:0] trial;
    logic             fits;

    assign shifted = {part[i+1], num_i[i]};
    assign trial   = shifted - {1'b0, den_i};
    assign fits    = (shifted >= {1'b0, den_i});
    assign quo_o[i] = fits;
    assign part[i]  = fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
  end

  assign rem_o = part[0];

endmodule

// File: rtl/radix_conv_ctrl.sv
module radix_conv_ctrl
  import radix_conv_pkg::*;
#(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OP_W-1:0]  value_i,
  input  logic [1:0]       radix_sel_i,
  input  logic [OP_W-1:0]  quo_i,
  output logic [OP_W-1:0]  cur_o,
  output logic [DEN_W-1:0] den_o,
  output logic             step_o,
  output logic             final_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} state_e;

  state_e           state_q, state_d;
  logic [OP_W-1:0]  cur_q, cur_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;
  logic             cur_en, den_en, cnt_en;

  assign accept  = start_i && (state_q == ST_IDLE);
  assign step_o  = (state_q == ST_RUN);
  assign final_o = step_o && (quo_i == '0);

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    den_d   = den_q;
    cnt_d   = cnt_q;
    cur_en  = 1'b0;
    den_en  = 1'b0;
    cnt_en  = 1'b0;
    if (accept) begin
      state_d = ST_RUN;
      cur_d   = value_i;
      den_d   = radix_of(radix_sel_i);
      cnt_d   = '0;
      cur_en  = 1'b1;
      den_en  = 1'b1;
      cnt_en  = 1'b1;
    end else if (step_o) begin
      cur_d  = quo_i;
      cnt_d  = cnt_q + 1'b1;
      cur_en = 1'b1;
      cnt_en = 1'b1;
      if (final_o) begin
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      den_q   <= 5'd2;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cur_en) cur_q <= cur_d;
      if (den_en) den_q <= den_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cur_o  = cur_q;
  assign den_o  = den_q;
  assign busy_o = (state_q == ST_RUN);
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/radix_digit_out.sv
module radix_digit_out
  import radix_conv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             final_i,
  input  logic [DEN_W-1:0] rem_i,
  output logic             valid_o,
  output logic             last_o,
  output logic [DIG_W-1:0] dig_o
);

  logic             valid_d, last_d;
  logic [DIG_W-1:0] dig_q, dig_d;
  logic             valid_q, last_q;
  logic             dig_en;

  always_comb begin
    valid_d = step_i;
    last_d  = final_i;
    dig_en  = step_i;
    dig_d   = rem_i[DIG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      dig_q   <= '0;
    end else begin
      valid_q <= valid_d;
      last_q  <= last_d;
      if (dig_en) dig_q <= dig_d;
    end
  end

  assign valid_o = valid_q;
  assign last_o  = last_q;
  assign dig_o   = dig_q;

endmodule

// File: rtl/radix_serial_conv.sv
module radix_serial_conv
  import radix_conv_pkg::*;
#(
  parameter int unsigned OP_W = 16,
  localparam int unsigned CNT_W = $clog2(OP_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OP_W-1:0]  value_i,
  input  logic [1:0]       radix_sel_i,
  output logic             busy_o,
  output logic             dig_valid_o,
  output logic             dig_last_o,
  output logic [DIG_W-1:0] dig_o,
  output logic [CNT_W-1:0] dig_count_o
);

  logic             rst_n_sync;
  logic [OP_W-1:0]  cur_val;
  logic [OP_W-1:0]  quo_val;
  logic [DEN_W-1:0] den_val;
  logic [DEN_W-1:0] rem_val;
  logic             step;
  logic             final_step;

  radix_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  radix_conv_ctrl #(.OP_W(OP_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .start_i     (start_i),
    .value_i     (value_i),
    .radix_sel_i (radix_sel_i),
    .quo_i       (quo_val),
    .cur_o       (cur_val),
    .den_o       (den_val),
    .step_o      (step),
    .final_o     (final_step),
    .busy_o      (busy_o),
    .cnt_o       (dig_count_o)
  );

  radix_restore_div #(.NUM_W(OP_W), .DEN_W(DEN_W)) u_div (
    .num_i (cur_val),
    .den_i (den_val),
    .quo_o (quo_val),
    .rem_o (rem_val)
  );

  radix_digit_out u_out (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .step_i  (step),
    .final_i (final_step),
    .rem_i   (rem_val),
    .valid_o (dig_valid_o),
    .last_o  (dig_last_o),
    .dig_o   (dig_o)
  );

endmodule

// File: rtl/radix_conv_chk.sv
module radix_conv_chk
  import radix_conv_pkg::*;
#(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [1:0]       radix_sel_i,
  input logic             busy_o,
  input logic             dig_valid_o,
  input logic             dig_last_o,
  input logic [DIG_W-1:0] dig_o,
  input logic [CNT_W-1:0] dig_count_o
);

  logic [DEN_W-1:0] rad_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad_seen <= 5'd16;
    end else if (start_i && !busy_o) begin
      rad_seen <= radix_of(radix_sel_i);
    end
  end

  AST_START_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !dig_valid_o && dig_count_o == '0)); // R2

  AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid_o |-> $past(busy_o)); // R3

  AST_MID_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid_o && !dig_last_o) |-> busy_o); // R4

  AST_LAST_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid_o && dig_last_o) |-> !busy_o); // R5

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dig_last_o |-> dig_valid_o); // R5

  AST_DIGIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid_o |-> ({1'b0, dig_o} < rad_seen)); // R7

  AST_IGNORE_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !(dig_valid_o && dig_last_o)) |=> (dig_count_o != '0)); // R8

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    dig_count_o <= CNT_W'(OP_W)); // R9

  AST_COUNT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(dig_count_o)); // R9

endmodule

bind radix_serial_conv radix_conv_chk #(.OP_W(OP_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .start_i     (start_i),
  .radix_sel_i (radix_sel_i),
  .busy_o      (busy_o),
  .dig_valid_o (dig_valid_o),
  .dig_last_o  (dig_last_o),
  .dig_o       (dig_o),
  .dig_count_o (dig_count_o)
);

// File: tb/radix_serial_conv_tb_top.sv
`timescale 1ns/1ps
module radix_serial_conv_tb_top;

  localparam int OP_W  = 16;
  localparam int CNT_W = 5;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [OP_W-1:0]  value_i;
  logic [1:0]       radix_sel_i;
  logic             busy_o;
  logic             dig_valid_o;
  logic             dig_last_o;
  logic [3:0]       dig_o;
  logic [CNT_W-1:0] dig_count_o;

  int n_checks;
  int n_errors;
  int cycles;

  radix_serial_conv #(.OP_W(OP_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .value_i     (value_i),
    .radix_sel_i (radix_sel_i),
    .busy_o      (busy_o),
    .dig_valid_o (dig_valid_o),
    .dig_last_o  (dig_last_o),
    .dig_o       (dig_o),
    .dig_count_o (dig_count_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_errors = n_errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_errors = n_errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int radix_val(input logic [1:0] sel);
    case (sel)
      2'd0: return 2;
      2'd1: return 8;
      2'd2: return 10;
      default: return 16;
    endcase
  endfunction

  // Starts a conversion at the current negedge and checks the whole stream.
  // Ends at the negedge that shows the last digit, so a following call is back to back.
  task automatic run_conv(input int val, input logic [1:0] sel, input bit poke_busy,
                          input string tag);
    int r = radix_val(sel);
    int v = val;
    int pos = 0;
    bit done = 0;
    start_i     = 1'b1;
    value_i     = val[OP_W-1:0];
    radix_sel_i = sel;
    @(negedge clk);
    start_i = 1'b0;
    value_i = '0;
    chk({tag, " R2 busy after start"}, busy_o === 1'b1, busy_o, 1);
    chk({tag, " R2 count cleared"}, dig_count_o === '0, dig_count_o, 0);
    chk({tag, " R3 no digit in load cycle"}, dig_valid_o === 1'b0, dig_valid_o, 0);
    while (!done) begin
      int ed;
      bit el;
      if (poke_busy && pos == 0) begin
        start_i     = 1'b1;
        value_i     = 16'h7777;
        radix_sel_i = 2'd0;
      end
      @(negedge clk);
      start_i = 1'b0;
      ed  = v % r;
      v   = v / r;
      el  = (v == 0);
      pos = pos + 1;
      chk({tag, " R4 digit valid"}, dig_valid_o === 1'b1, dig_valid_o, 1);
      chk({tag, (r == 16 && ed > 9) ? " R7 hex digit" : " R4 digit value"},
          dig_o === ed[3:0], dig_o, ed);
      chk({tag, " R5 last flag"}, dig_last_o === el, dig_last_o, el);
      chk({tag, " R9 count"}, dig_count_o === pos[CNT_W-1:0], dig_count_o, pos);
      chk({tag, " R5 busy"}, busy_o === !el, busy_o, !el);
      if (poke_busy && pos == 1)
        chk({tag, " R8 busy start ignored"}, dig_valid_o === 1'b1, dig_valid_o, 1);
      done = el;
      if (pos > OP_W + 2) begin
        chk({tag, " R5 stream too long"}, 1'b0, pos, OP_W);
        done = 1;
      end
    end
  endtask

  task automatic check_idle(input int exp_cnt, input string tag);
    @(negedge clk);
    chk({tag, " R5 idle valid"}, dig_valid_o === 1'b0, dig_valid_o, 0);
    chk({tag, " R5 idle busy"}, busy_o === 1'b0, busy_o, 0);
    chk({tag, " R9 count holds"}, dig_count_o === exp_cnt[CNT_W-1:0], dig_count_o, exp_cnt);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start_i = 1'b0;
    value_i = '0;
    radix_sel_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy_o === 1'b0, busy_o, 0);
    chk("R1 valid", dig_valid_o === 1'b0, dig_valid_o, 0);
    chk("R1 last", dig_last_o === 1'b0, dig_last_o, 0);
    chk("R1 count", dig_count_o === '0, dig_count_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", busy_o === 1'b0, busy_o, 0);
  endtask

  task automatic t_example();
    run_conv(13, 2'd0, 0, "bin13");
    check_idle(4, "bin13");
  endtask

  task automatic t_zero();
    run_conv(0, 2'd2, 0, "zero R6");
    check_idle(1, "zero R6");
  endtask

  task automatic t_all_ones();
    run_conv(16'hFFFF, 2'd0, 0, "ones2");
    check_idle(16, "ones2 R9 max");
    run_conv(16'hFFFF, 2'd1, 0, "ones8");
    check_idle(6, "ones8");
    run_conv(16'hFFFF, 2'd2, 0, "ones10");
    check_idle(5, "ones10");
    run_conv(16'hFFFF, 2'd3, 0, "ones16");
    check_idle(4, "ones16");
  endtask

  task automatic t_hex();
    run_conv(16'hABCD, 2'd3, 0, "hexABCD R7");
    check_idle(4, "hexABCD");
    run_conv(16'h0F00, 2'd3, 0, "hex0F00");
    check_idle(3, "hex0F00");
  endtask

  task automatic t_dec_bounds();
    run_conv(9, 2'd2, 0, "dec9");
    check_idle(1, "dec9");
    run_conv(10, 2'd2, 0, "dec10");
    check_idle(2, "dec10");
    run_conv(99, 2'd2, 0, "dec99");
    check_idle(2, "dec99");
    run_conv(511, 2'd1, 0, "oct511");
    check_idle(3, "oct511");
  endtask

  task automatic t_busy_start();
    run_conv(12345, 2'd2, 1, "busy R8");
    check_idle(5, "busy R8");
  endtask

  task automatic t_back_to_back();
    run_conv(200, 2'd3, 0, "b2b first R10");
    run_conv(5, 2'd0, 0, "b2b second R10");
    run_conv(1, 2'd1, 0, "b2b third R10");
    check_idle(1, "b2b R10");
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    cycles   = 0;
    t_reset();
    t_example();
    t_zero();
    t_all_ones();
    t_hex();
    t_dec_bounds();
    t_busy_start();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule